// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs on the host side of a single-channel, 12-bit, serial-output analog-to-digital converter. It uses a three-wire link: an active-low chip select, a serial clock and one data line from the converter. When it accepts a start request, it pulls chip select low, and that falling edge starts a conversion. It then produces fifteen serial clock pulses, made from the system clock with a programmable half-period divider. It captures the returned bits through a two-stage synchronizer and presents the 12-bit result with a one-cycle valid strobe.

The serial clock is held low whenever chip select is high. The first data bit is ignored. The next two bits must be zero, and a framing-error flag reports any that are not. The twelve bits after them form the sample, most significant bit first. Each bit is captured one system cycle before the rising edge that follows the edge that launched it. Two hold-off windows decide when the next frame may start. One is a minimum distance between frame starts, which paces the sample rate. The other is a minimum time that chip select stays high between frames. A start request that arrives while the block is busy is dropped, not queued.

The parameters fix the system clock frequency, the serial clock ceiling and the maximum sample rate. The block derives its minimum serial half period and its minimum start spacing from them. At the defaults (250 MHz, 4.8 MHz, 300 ksps) these are 27 and 834 system cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o=1, sclk_o=0, sample_vld_o=0, busy_o=0, frame_err_o=0 and sample_o=0.
- R2: A start accepted at a clock edge drives cs_n_o low from that edge with sclk_o low. sclk_o stays low for exactly one half period before its first rise, and it is low whenever cs_n_o is high.
- R3: Every frame has exactly 15 rising edges of sclk_o. cs_n_o rises exactly one half period after the 15th falling edge.
- R4: Every high and low phase of sclk_o lasts H = max(half_div_i, MIN_HALF) system cycles. MIN_HALF = ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)), which is 27 at the defaults. H is latched at frame start.
- R5: sample_o holds the bits that were present on sdi_i before rising edges 4 through 15. The bit before edge 4 lands in bit 11 (MSB first). The bit present before the first rising edge has no effect on any output.
- R6: frame_err_o is 1 exactly when either of the bits present before rising edges 2 and 3 was 1.
- R7: sample_vld_o pulses for one cycle, in the same cycle that cs_n_o returns high. sample_o and frame_err_o keep their values until the next pulse.
- R8: start_i while busy_o=1 is ignored and is not remembered later.
- R9: Two chip-select falling edges are at least max(rate_i, MIN_RATE) system cycles apart. MIN_RATE = ceil(SYS_CLK_HZ / MAX_SPS), which is 834 at the defaults. With start_i held high, the spacing is exactly max(that value, frame length + chip-select high time).
- R10: Between frames cs_n_o stays high for at least max(gap_i, 1) system cycles. With start_i held high it stays high for exactly that long.
- R11: busy_o is 1 from the chip-select falling edge until the frame has ended and both hold-off windows have expired. It drops in the last cycle before a new start would be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one conversion frame |
| half_div_i | input | DIV_W | Requested serial clock half period in system cycles |
| rate_i | input | RATE_W | Minimum system cycles between frame starts |
| gap_i | input | GAP_W | Minimum system cycles chip select stays high between frames |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock to the converter |
| sample_o | output | 12 | Last captured result |
| sample_vld_o | output | 1 | One-cycle strobe, new result on sample_o |
| frame_err_o | output | 1 | Leading bits of the last frame were not zero |
| busy_o | output | 1 | Frame in progress or hold-off running |

## Verification
Six result words are captured through the converter model. All-ones and all-zeros show that bit order and leading-bit stripping are right. A lone LSB and a lone MSB expose a shift that is one bit off in either direction. The mixed patterns A5C and 3C7 catch swapped or reversed nibbles. A 1 placed in each leading position, with no error expected when the ignored first bit alone is 1, shows which sampled positions the framing check covers. Divider values below, at and above the floor show whether the serial clock period comes from the clamp or from the input. Held start requests with a long rate window, a long gap and neither show which of the two hold-offs, or the frame itself, sets the spacing between frames.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int SAMPLE_W    = 12;
  localparam int LEAD_ZEROS  = 2;
  // one ignored bit, the leading zeros, then the result
  localparam int FRAME_EDGES = 1 + LEAD_ZEROS + SAMPLE_W;
  localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW
  } seq_st_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_rd_holdoff.sv
module adc_rd_holdoff #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         open_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load_i || (cnt_q != '0);
    if (load_i)
      cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q == '0);

  // R9 / R10: a window longer than one cycle keeps the gate shut next cycle
  a_r9_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (len_i > W'(1))) |=> !open_o);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [DIV_W-1:0]    half_i,
  input  logic                sdi_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                err_o,
  output logic                active_o,
  output logic                done_o
);
  localparam logic [EDGE_W-1:0] EDGES_LAST = EDGE_W'(FRAME_EDGES);
  localparam logic [EDGE_W-1:0] LEAD_HI    = EDGE_W'(LEAD_ZEROS);

  seq_st_e             st_q, st_d;
  logic [DIV_W-1:0]    ph_q, ph_d, half_q, half_d;
  logic [EDGE_W-1:0]   edges_q, edges_d;
  logic [SAMPLE_W-1:0] shift_q, shift_d, sample_q;
  logic                lead_bad_q, lead_bad_d;
  logic                cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic                valid_q, err_q;
  logic                last_ph, pre_ph, capture, finish;

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    half_d     = half_q;
    edges_d    = edges_q;
    shift_d    = shift_q;
    lead_bad_d = lead_bad_q;
    cs_n_d     = cs_n_q;
    sclk_d     = sclk_q;
    finish     = 1'b0;
    last_ph    = (ph_q == half_q - 1'b1);
    pre_ph     = (ph_q == half_q - DIV_W'(2));
    capture    = ((st_q == ST_LEAD) || (st_q == ST_LOW)) && pre_ph && (edges_q < EDGES_LAST);

    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          st_d       = ST_LEAD;
          ph_d       = '0;
          half_d     = half_i;
          edges_d    = '0;
          lead_bad_d = 1'b0;
          cs_n_d     = 1'b0;
          sclk_d     = 1'b0;
        end
      end
      ST_LEAD, ST_HIGH: begin
        if (last_ph) begin
          ph_d = '0;
          if (st_q == ST_LEAD) begin
            st_d    = ST_HIGH;
            sclk_d  = 1'b1;
            edges_d = edges_q + 1'b1;
          end else begin
            st_d   = ST_LOW;
            sclk_d = 1'b0;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_LOW: begin
        if (last_ph) begin
          ph_d = '0;
          if (edges_q == EDGES_LAST) begin
            st_d   = ST_IDLE;
            cs_n_d = 1'b1;
            finish = 1'b1;
          end else begin
            st_d    = ST_HIGH;
            sclk_d  = 1'b1;
            edges_d = edges_q + 1'b1;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    // bit number edges_q+1: first ignored, next LEAD_ZEROS checked, rest shifted
    if (capture) begin
      if ((edges_q != '0) && (edges_q <= LEAD_HI))
        lead_bad_d = lead_bad_q | sdi_i;
      else if (edges_q > LEAD_HI)
        shift_d = {shift_q[SAMPLE_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= '0;
      half_q     <= DIV_W'(MIN_HALF);
      edges_q    <= '0;
      shift_q    <= '0;
      lead_bad_q <= 1'b0;
      cs_n_q     <= 1'b1;
      sclk_q     <= 1'b0;
      valid_q    <= 1'b0;
      sample_q   <= '0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      half_q     <= half_d;
      edges_q    <= edges_d;
      shift_q    <= shift_d;
      lead_bad_q <= lead_bad_d;
      cs_n_q     <= cs_n_d;
      sclk_q     <= sclk_d;
      valid_q    <= finish;
      if (finish) begin
        sample_q <= shift_q;
        err_q    <= lead_bad_q;
      end
    end
  end

  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign err_o    = err_q;
  assign active_o = (st_q != ST_IDLE);
  assign done_o   = finish;

  // R2: serial clock idles low outside a frame
  a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q);
  // R3: never more than the frame's rising edges
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edges_q <= EDGES_LAST);
  // R4: the latched half period respects the floor
  a_r4_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> (half_q >= DIV_W'(MIN_HALF)));
  // R7: strobe lasts one cycle and coincides with deselect
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r7_strobe_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $rose(cs_n_q));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 250_000_000,
  parameter int SCLK_MAX_HZ = 4_800_000,
  parameter int MAX_SPS     = 300_000,
  parameter int DIV_W       = 8,
  parameter int RATE_W      = 16,
  parameter int GAP_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [DIV_W-1:0]    half_div_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [GAP_W-1:0]    gap_i,
  input  logic                sdi_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                frame_err_o,
  output logic                busy_o
);
  localparam int HALF_RAW = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int MIN_HALF = (HALF_RAW < 2) ? 2 : HALF_RAW;
  localparam int MIN_RATE = (SYS_CLK_HZ + MAX_SPS - 1) / MAX_SPS;

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              sdi_sync, go, active, done, rate_open, gap_open;
  logic [DIV_W-1:0]  half_eff;
  logic [RATE_W-1:0] rate_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign half_eff = (half_div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div_i;
  assign rate_eff = (rate_i < RATE_W'(MIN_RATE)) ? RATE_W'(MIN_RATE) : rate_i;
  assign busy_o   = active || !rate_open || !gap_open;
  assign go       = start_i && !busy_o;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(sdi_i), .q_o(sdi_sync)
  );

  adc_rd_holdoff #(.W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_core_n), .load_i(go), .len_i(rate_eff), .open_o(rate_open)
  );

  adc_rd_holdoff #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_core_n), .load_i(done), .len_i(gap_i), .open_o(gap_open)
  );

  adc_rd_seq #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .go_i(go), .half_i(half_eff), .sdi_i(sdi_sync),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sample_o(sample_o), .valid_o(sample_vld_o),
    .err_o(frame_err_o), .active_o(active), .done_o(done)
  );

  // R8: a frame only begins from a non-busy state
  a_r8_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(cs_n_o) |-> $past(!busy_o));
  // R11: busy covers the whole selected interval
  a_r11_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cs_n_o |-> busy_o);
endmodule

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  half = 8'd27;
  logic [15:0] rate = '0;
  logic [11:0] gap = '0;
  logic        sdi = 1'b0;
  logic        cs_n, sclk, vld, ferr, busy;
  logic [11:0] sample;

  int total = 0, bad = 0, cyc = 0;
  // converter model and monitor state
  logic [11:0] cur_word = '0;
  logic [1:0]  cur_lead = '0;
  logic        cur_first = 1'b0;
  int exp_h = 27, e = 0, mism = 0, vcount = 0, n_falls = 0;
  int fall_prev = 0, fall_last = 0, rise_cs = 0, valid_cyc = 0, last_evt = 0;
  logic got_valid = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b0;

  localparam logic [34:0] VEC [6] = '{
    {8'd27, 12'd0,  12'hA5C, 2'b00, 1'b1},
    {8'd5,  12'd10, 12'hFFF, 2'b00, 1'b0},
    {8'd40, 12'd0,  12'h001, 2'b00, 1'b1},
    {8'd30, 12'd3,  12'h800, 2'b10, 1'b0},
    {8'd27, 12'd0,  12'h000, 2'b01, 1'b0},
    {8'd33, 12'd0,  12'h3C7, 2'b00, 1'b0}
  };

  adc_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_div_i(half), .rate_i(rate),
    .gap_i(gap), .sdi_i(sdi), .cs_n_o(cs_n), .sclk_o(sclk), .sample_o(sample),
    .sample_vld_o(vld), .frame_err_o(ferr), .busy_o(busy)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      n_falls++; fall_prev = fall_last; fall_last = cyc;
      e = 0; last_evt = cyc; sdi = cur_first;
    end
    if (!cs_n && sclk && !prev_sclk) begin
      e++;
      if (cyc - last_evt != exp_h) mism++;
      last_evt = cyc;
      if (e <= 2)       sdi = cur_lead[2-e];
      else if (e <= 14) sdi = cur_word[14-e];
      else              sdi = 1'b0;
    end
    if (!sclk && prev_sclk) begin
      if (cyc - last_evt != exp_h) mism++;
      last_evt = cyc;
    end
    if (!prev_cs && cs_n) begin
      if (cyc - last_evt != exp_h) mism++;
      rise_cs = cyc; sdi = 1'b0;
    end
    if (vld) begin vcount++; valid_cyc = cyc; got_valid = 1'b1; end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic one_frame();
    while (busy) @(negedge clk);
    got_valid = 1'b0; vcount = 0; mism = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!got_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r, f0;
    logic [11:0] hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n", cs_n, 1);   chk("R1 sclk", sclk, 0);
    chk("R1 valid", vld, 0);   chk("R1 busy", busy, 0);
    chk("R1 err", ferr, 0);    chk("R1 sample", sample, 0);

    for (int i = 0; i < 6; i++) begin
      half = VEC[i][34:27]; gap = VEC[i][26:15]; cur_word = VEC[i][14:3];
      cur_lead = VEC[i][2:1]; cur_first = VEC[i][0];
      exp_h = (half < 8'd27) ? 27 : int'(half);
      one_frame();
      chk("R5 sample", sample, cur_word);
      chk("R6 frame error", ferr, int'(|cur_lead));
      chk("R3 rising edges", e, 15);
      chk("R2/R4 phase lengths", mism, 0);
      chk("R7 strobe at deselect", valid_cyc, rise_cs);
      chk("R7 strobe count", vcount, 1);
      hold = sample;
      repeat (20) @(negedge clk);
      chk("R7 sample held", sample, hold);
      chk("R7 strobe low", vld, 0);
    end

    // R8: request during a frame is dropped
    half = 8'd27; exp_h = 27; gap = '0; rate = '0; cur_lead = '0; cur_first = 1'b0;
    while (busy) @(negedge clk);
    f0 = n_falls; got_valid = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (200) @(negedge clk);
    chk("R11 busy mid-frame", busy, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!got_valid) @(negedge clk);
    repeat (300) @(negedge clk);
    chk("R8 ignored start", n_falls - f0, 1);

    // R10 / R11: gap window and busy release
    gap = 12'd500;
    one_frame();
    r = rise_cs;
    while (cyc != r + 498) @(negedge clk);
    chk("R11 busy in gap", busy, 1);
    @(negedge clk);
    chk("R11 busy released", busy, 0);
    f0 = n_falls; start = 1'b1;
    while (n_falls < f0 + 2) @(negedge clk);
    start = 1'b0;
    chk("R10 gap high time", fall_last - rise_cs, 500);
    chk("R9 spacing with gap", fall_last - fall_prev, 837 + 500);

    // R9 / R11: rate window dominates
    while (busy) @(negedge clk);
    gap = '0; rate = 16'd3000;
    f0 = n_falls; start = 1'b1;
    while (n_falls < f0 + 2) @(negedge clk);
    chk("R9 rate spacing", fall_last - fall_prev, 3000);
    r = fall_last;
    while (cyc != r + 2998) @(negedge clk);
    chk("R11 busy in rate window", busy, 1);
    @(negedge clk);
    chk("R11 busy after rate window", busy, 0);
    start = 1'b0;

    // R9 / R10: neither window, frame length plus one cycle
    while (busy) @(negedge clk);
    rate = '0;
    f0 = n_falls; start = 1'b1;
    while (n_falls < f0 + 2) @(negedge clk);
    start = 1'b0;
    chk("R10 minimum high time", fall_last - rise_cs, 1);
    chk("R9 back-to-back spacing", fall_last - fall_prev, 838);

    while (busy) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule